// File: doc/BRIEF.md
# Multicore Interrupt and IPI Distributor

This block is the interrupt controller of a small multiprocessor with `NUM_CORES` cores. After reset only core 0 runs. Every other core is held with its run output low until another core sends it an inter-processor interrupt (IPI). That first IPI starts the core and shows it the vector of the handler to run. Software on a running core reaches the block through a small register bus that carries a privilege flag. Sending an IPI and writing the core-ID table both need privilege.

Software names IPI targets by a virtual core ID. A table in the block turns each virtual ID into a physical core number. Virtual ID 0 always means core 0. The other entries are filled in at boot and may point at any physical cores, in any order.

External interrupt lines are level-sensitive. The lowest-numbered active line is delivered first. They are routed by one of two policies chosen by a control bit. In the fixed policy everything goes to core 0. In the rotating policy the target moves on to the next running core after each delivery.

Top module: `ipi_dist_top`

## Requirements
- R1: After reset `coreRun` is 0001 (only core 0 runs), the error flag reads 0 and the fixed policy is selected. A bit of `coreRun` that is set never clears again until reset.
- R2: A privileged write to address 1 sends an IPI. Bits [7:0] of the write data hold the vector and bits [9:8] hold the virtual target ID. The target physical core gets its run bit and its IPI-pending bit set on the following clock edge, and its `coreVec` shows the sent vector.
- R3: With control bit 0 at 0 (fixed policy), every external interrupt is delivered to core 0.
- R4: With control bit 0 at 1 (rotating policy), after each external delivery the target moves to the next core in ascending order, wrapping to 0, that has its run bit set. Halted cores are skipped.
- R5: In the rotating policy, when core 0 is the only running core, every external interrupt goes to core 0.
- R6: Address 2+v holds the entry for virtual ID v. Write data bit 15 is the valid flag and bits [1:0] are the physical core. A read of that address returns the same layout. Entry 0 reads 0x8000, and any write to it is dropped and sets the error flag.
- R7: A write to address 1 or to any table address without the privilege flag is dropped and sets the error flag.
- R8: An IPI naming a virtual ID whose entry is not valid is dropped: no run, pending or vector change. It sets the error flag.
- R9: The error flag reads at bit 1 of address 0 and stays set until a write to address 0 with data bit 7 set clears it. Control writes need no privilege.
- R10: Each core has one IPI-pending and one external-pending bit, and `coreIrq` is their OR. An `coreAck` pulse clears the IPI bit if it is set, otherwise the external bit. A second IPI to a core whose IPI bit is still set is merged and leaves the first vector in place.
- R11: An external delivery sets the target's external-pending bit with vector 0x20 plus the index of the lowest active line. No delivery happens while the target's external-pending bit is still set.
- R12: When both pending bits of a core are set, its `coreVec` shows the IPI vector. After the IPI is acknowledged it shows the external vector again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register address |
| busWrData | input | 16 | Register write data |
| busPriv | input | 1 | Write comes from privileged code |
| busRdData | output | 16 | Read data for `busAddr` (combinational) |
| irqLines | input | 4 | Level-sensitive external interrupt requests |
| coreAck | input | 4 | Per-core acknowledge pulse |
| coreRun | output | 4 | Per-core run enable |
| coreIrq | output | 4 | Per-core interrupt request |
| coreVec | output | 32 | Per-core vector, core i at bits [8i+7:8i] |

## Verification
The assertions check on every cycle the properties that need no scenario:
- run bits never fall;
- an accepted IPI starts and flags its target on the next edge;
- an unprivileged write changes no run or table state;
- at most one external-pending bit rises per cycle, and only on a running core;
- no core other than 0 receives an external interrupt under the fixed policy.

Only the bench's scenarios can show the rest:
- the order of the rotation and the skipping of halted cores;
- the priority among lines and the vectors chosen;
- the merging of IPIs and which pending bit an acknowledge clears;
- the table translation, and the sticky error flag with its clearing.

// File: rtl/ipi_dist_pkg.sv
package ipi_dist_pkg;

  typedef struct packed {
    logic modeWr;
    logic errClr;
    logic errSet;
    logic ipiReq;
    logic mapWr;
    logic extDeliver;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CTRL = 2'd1,
    RD_MAP  = 2'd2
  } rdSel_t;

endpackage

// File: rtl/ipi_dist_ctrl.sv
module ipi_dist_ctrl
  import ipi_dist_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_IRQ   = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int MAP_BASE  = 2,
  parameter int CLR_BIT   = 7,
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int IRQ_W    = $clog2(NUM_IRQ)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWrData,
  input  logic                 busPriv,
  input  logic [NUM_IRQ-1:0]   irqLines,
  input  logic [NUM_CORES-1:0] coreRun,
  input  logic [NUM_CORES-1:0] extPend,
  input  logic                 rotateMode,
  output ctrlStrobes_t         strb,
  output rdSel_t               rdSel,
  output logic [CORE_W-1:0]    mapIdx,
  output logic [CORE_W-1:0]    extTarget,
  output logic [IRQ_W-1:0]     extIdx
);

  logic                isCtrl, isIpi, isMap, anyIrq, found;
  logic [ADDR_W-1:0]   relAddr;
  logic [CORE_W-1:0]   rotPtr, nextPtr;

  // Address decode
  assign relAddr = busAddr - ADDR_W'(MAP_BASE);
  assign isCtrl  = (busAddr == '0);
  assign isIpi   = (busAddr == ADDR_W'(1));
  assign isMap   = (int'(busAddr) >= MAP_BASE) && (int'(busAddr) < MAP_BASE + NUM_CORES);
  assign mapIdx  = relAddr[CORE_W-1:0];

  always_comb begin
    if (isCtrl)     rdSel = RD_CTRL;
    else if (isMap) rdSel = RD_MAP;
    else            rdSel = RD_NONE;
  end

  // Lowest-index active line wins
  always_comb begin
    extIdx = '0;
    anyIrq = 1'b0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (irqLines[i]) begin
        extIdx = IRQ_W'(i);
        anyIrq = 1'b1;
      end
    end
  end

  assign extTarget = rotateMode ? rotPtr : '0;

  // Next running core after the current target, wrapping
  always_comb begin
    nextPtr = '0;
    found   = 1'b0;
    for (int k = 1; k < NUM_CORES; k++) begin
      int c;
      c = int'(extTarget) + k;
      if (c >= NUM_CORES) c = c - NUM_CORES;
      if (!found && coreRun[c]) begin
        nextPtr = CORE_W'(c);
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    strb            = '0;
    strb.modeWr     = busWrEn && isCtrl;
    strb.errClr     = busWrEn && isCtrl && busWrData[CLR_BIT];
    strb.ipiReq     = busWrEn && isIpi && busPriv;
    strb.mapWr      = busWrEn && isMap && busPriv && (mapIdx != '0);
    strb.errSet     = busWrEn && (((isIpi || isMap) && !busPriv) ||
                                  (isMap && busPriv && (mapIdx == '0)));
    strb.extDeliver = anyIrq && !extPend[extTarget];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rotPtr <= '0;
    end else if (strb.extDeliver && rotateMode) begin
      rotPtr <= nextPtr;
    end
  end

  assert_rot_target_running_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.extDeliver && rotateMode) |-> coreRun[extTarget]);

endmodule

// File: rtl/ipi_dist_datapath.sv
module ipi_dist_datapath
  import ipi_dist_pkg::*;
#(
  parameter int NUM_CORES    = 4,
  parameter int NUM_IRQ      = 4,
  parameter int DATA_W       = 16,
  parameter int VEC_W        = 8,
  parameter int VID_LSB      = 8,
  parameter int EXT_VEC_BASE = 32,
  localparam int CORE_W      = $clog2(NUM_CORES),
  localparam int IRQ_W       = $clog2(NUM_IRQ)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strb,
  input  rdSel_t                     rdSel,
  input  logic [CORE_W-1:0]          mapIdx,
  input  logic [CORE_W-1:0]          extTarget,
  input  logic [IRQ_W-1:0]           extIdx,
  input  logic [DATA_W-1:0]          busWrData,
  input  logic                       busWrEn,
  input  logic                       busPriv,
  input  logic [NUM_CORES-1:0]       coreAck,
  output logic [DATA_W-1:0]          busRdData,
  output logic                       rotateMode,
  output logic [NUM_CORES-1:0]       coreRun,
  output logic [NUM_CORES-1:0]       extPend,
  output logic [NUM_CORES-1:0]       coreIrq,
  output logic [NUM_CORES*VEC_W-1:0] coreVec
);

  logic                errSticky;
  logic [NUM_CORES-1:0] ipiPend, mapValid;
  logic [CORE_W-1:0]   mapPhys [NUM_CORES];
  logic [VEC_W-1:0]    ipiVec  [NUM_CORES];
  logic [VEC_W-1:0]    extVec  [NUM_CORES];
  logic [CORE_W-1:0]   ipiVid, ipiPhys;
  logic                ipiOk, ipiFire, ipiDrop;
  logic [VEC_W-1:0]    newExtVec;

  // Virtual-to-physical translation
  assign ipiVid  = busWrData[VID_LSB +: CORE_W];
  assign ipiPhys = (ipiVid == '0) ? '0 : mapPhys[ipiVid];
  assign ipiOk   = (ipiVid == '0) || mapValid[ipiVid];
  assign ipiFire = strb.ipiReq && ipiOk;
  assign ipiDrop = strb.ipiReq && !ipiOk;
  assign newExtVec = VEC_W'(EXT_VEC_BASE) + VEC_W'(extIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rotateMode <= 1'b0;
      errSticky  <= 1'b0;
      mapValid   <= '0;
      coreRun    <= NUM_CORES'(1);
      ipiPend    <= '0;
      extPend    <= '0;
      for (int i = 0; i < NUM_CORES; i++) begin
        mapPhys[i] <= '0;
        ipiVec[i]  <= '0;
        extVec[i]  <= '0;
      end
    end else begin
      if (strb.modeWr) rotateMode <= busWrData[0];
      errSticky <= (errSticky && !strb.errClr) || strb.errSet || ipiDrop;
      if (strb.mapWr) begin
        mapPhys[mapIdx]  <= busWrData[CORE_W-1:0];
        mapValid[mapIdx] <= busWrData[DATA_W-1];
      end
      for (int i = 0; i < NUM_CORES; i++) begin
        if (ipiFire && (ipiPhys == CORE_W'(i))) begin
          coreRun[i] <= 1'b1;
          ipiPend[i] <= 1'b1;
          if (!ipiPend[i]) ipiVec[i] <= busWrData[VEC_W-1:0];
        end else if (coreAck[i] && ipiPend[i]) begin
          ipiPend[i] <= 1'b0;
        end
        if (strb.extDeliver && (extTarget == CORE_W'(i))) begin
          extPend[i] <= 1'b1;
          extVec[i]  <= newExtVec;
        end else if (coreAck[i] && !ipiPend[i]) begin
          extPend[i] <= 1'b0;
        end
      end
    end
  end

  assign coreIrq = ipiPend | extPend;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_vec
    assign coreVec[g*VEC_W +: VEC_W] = ipiPend[g] ? ipiVec[g] : extVec[g];
  end

  always_comb begin
    busRdData = '0;
    case (rdSel)
      RD_CTRL: begin
        busRdData[0] = rotateMode;
        busRdData[1] = errSticky;
      end
      RD_MAP: begin
        if (mapIdx == '0) begin
          busRdData[DATA_W-1] = 1'b1;
        end else begin
          busRdData[DATA_W-1]   = mapValid[mapIdx];
          busRdData[CORE_W-1:0] = mapPhys[mapIdx];
        end
      end
      default: busRdData = '0;
    endcase
  end

  // Assertions
  assert_run_sticky_R1: assert property (@(posedge clk) disable iff (!rstN)
    (coreRun & $past(coreRun)) == $past(coreRun));

  assert_ipi_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    ipiFire |=> (coreRun[$past(ipiPhys)] && ipiPend[$past(ipiPhys)]));

  assert_fixed_core0_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((extPend & ~$past(extPend) & ~NUM_CORES'(1)) != '0) |-> $past(rotateMode));

  assert_one_delivery_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(extPend & ~$past(extPend)));

  assert_ext_to_running_R5: assert property (@(posedge clk) disable iff (!rstN)
    (extPend & ~$past(extPend) & ~$past(coreRun)) == '0);

  assert_unpriv_dropped_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !busPriv) |=> ($stable(coreRun) && $stable(mapValid)));

endmodule

// File: rtl/ipi_dist_top.sv
module ipi_dist_top
  import ipi_dist_pkg::*;
#(
  parameter int NUM_CORES    = 4,
  parameter int NUM_IRQ      = 4,
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 16,
  parameter int VEC_W        = 8,
  parameter int EXT_VEC_BASE = 32,
  localparam int CORE_W      = $clog2(NUM_CORES),
  localparam int IRQ_W       = $clog2(NUM_IRQ)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWrEn,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWrData,
  input  logic                       busPriv,
  output logic [DATA_W-1:0]          busRdData,
  input  logic [NUM_IRQ-1:0]         irqLines,
  input  logic [NUM_CORES-1:0]       coreAck,
  output logic [NUM_CORES-1:0]       coreRun,
  output logic [NUM_CORES-1:0]       coreIrq,
  output logic [NUM_CORES*VEC_W-1:0] coreVec
);

  ctrlStrobes_t         strb;
  rdSel_t               rdSel;
  logic [CORE_W-1:0]    mapIdx, extTarget;
  logic [IRQ_W-1:0]     extIdx;
  logic [NUM_CORES-1:0] extPend;
  logic                 rotateMode;

  ipi_dist_ctrl #(
    .NUM_CORES(NUM_CORES), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busPriv(busPriv), .irqLines(irqLines),
    .coreRun(coreRun), .extPend(extPend), .rotateMode(rotateMode),
    .strb(strb), .rdSel(rdSel), .mapIdx(mapIdx), .extTarget(extTarget),
    .extIdx(extIdx)
  );

  ipi_dist_datapath #(
    .NUM_CORES(NUM_CORES), .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .VEC_W(VEC_W),
    .EXT_VEC_BASE(EXT_VEC_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .mapIdx(mapIdx),
    .extTarget(extTarget), .extIdx(extIdx), .busWrData(busWrData),
    .busWrEn(busWrEn), .busPriv(busPriv), .coreAck(coreAck),
    .busRdData(busRdData), .rotateMode(rotateMode), .coreRun(coreRun),
    .extPend(extPend), .coreIrq(coreIrq), .coreVec(coreVec)
  );

endmodule

// File: tb/tb_ipi_dist_top.sv
`timescale 1ns/1ps
module tb_ipi_dist_top;

  localparam real CLK_P = 5.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic        busPriv = 1'b0;
  logic [15:0] busRdData;
  logic [3:0]  irqLines = '0;
  logic [3:0]  coreAck = '0;
  logic [3:0]  coreRun, coreIrq;
  logic [31:0] coreVec;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_P / 2.0) clk = ~clk;

  ipi_dist_top dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busPriv(busPriv), .busRdData(busRdData),
    .irqLines(irqLines), .coreAck(coreAck), .coreRun(coreRun),
    .coreIrq(coreIrq), .coreVec(coreVec)
  );

  typedef struct packed {
    logic [3:0]  addr;
    logic [15:0] data;
    logic        priv;
    logic [3:0]  expRun;
    logic        expErr;
    logic [3:0]  expIrq;
  } vecEntry_t;

  localparam int NV = 14;
  localparam vecEntry_t TBL [NV] = '{
    '{4'd3, 16'h8003, 1'b0, 4'b0001, 1'b1, 4'b0000}, // R7 unprivileged map write
    '{4'd0, 16'h0080, 1'b1, 4'b0001, 1'b0, 4'b0000}, // R9 clear
    '{4'd1, 16'h0120, 1'b1, 4'b0001, 1'b1, 4'b0000}, // R8 unmapped vid 1
    '{4'd0, 16'h0080, 1'b0, 4'b0001, 1'b0, 4'b0000}, // R9 clear, no privilege
    '{4'd3, 16'h8003, 1'b1, 4'b0001, 1'b0, 4'b0000}, // R6 vid1 -> core3
    '{4'd4, 16'h8001, 1'b1, 4'b0001, 1'b0, 4'b0000}, // R6 vid2 -> core1
    '{4'd5, 16'h8002, 1'b1, 4'b0001, 1'b0, 4'b0000}, // R6 vid3 -> core2
    '{4'd1, 16'h0140, 1'b0, 4'b0001, 1'b1, 4'b0000}, // R7 unprivileged IPI
    '{4'd0, 16'h0080, 1'b1, 4'b0001, 1'b0, 4'b0000}, // R9 clear
    '{4'd1, 16'h0140, 1'b1, 4'b1001, 1'b0, 4'b1000}, // R2 IPI vid1 vec 0x40
    '{4'd1, 16'h0141, 1'b1, 4'b1001, 1'b0, 4'b1000}, // R10 merged IPI
    '{4'd2, 16'h8003, 1'b1, 4'b1001, 1'b1, 4'b1000}, // R6 entry 0 locked
    '{4'd0, 16'h0080, 1'b1, 4'b1001, 1'b0, 4'b1000}, // R9 clear
    '{4'd1, 16'h0050, 1'b1, 4'b1001, 1'b0, 4'b1001}  // R2 IPI vid0 vec 0x50
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d, input logic p);
    @(negedge clk);
    busAddr = a; busWrData = d; busPriv = p; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busPriv = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic pulseIrq(input logic [3:0] lines);
    @(negedge clk);
    irqLines = lines;
    @(negedge clk);
    irqLines = '0;
  endtask

  task automatic ackCores(input logic [3:0] m);
    @(negedge clk);
    coreAck = m;
    @(negedge clk);
    coreAck = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [7:0] vecOf(input int c);
    return coreVec[c*8 +: 8];
  endfunction

  initial begin
    #(CLK_P * 150000);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    doReset();
    chk("R1 reset run", 32'(coreRun), 32'h1);
    busRead(4'd0, rd);
    chk("R1 reset ctrl", 32'(rd), 32'h0);

    for (int i = 0; i < NV; i++) begin
      busWrite(TBL[i].addr, TBL[i].data, TBL[i].priv);
      chk($sformatf("R2/R7 vec%0d run", i), 32'(coreRun), 32'(TBL[i].expRun));
      chk($sformatf("R10 vec%0d irq", i), 32'(coreIrq), 32'(TBL[i].expIrq));
      busRead(4'd0, rd);
      chk($sformatf("R9 vec%0d err", i), 32'(rd[1]), 32'(TBL[i].expErr));
    end

    chk("R10 merge keeps first vector", 32'(vecOf(3)), 32'h40);
    chk("R2 core0 vector", 32'(vecOf(0)), 32'h50);
    ackCores(4'b1001);
    chk("R10 ack clears", 32'(coreIrq), 32'h0);
    busRead(4'd3, rd);
    chk("R6 map readback", 32'(rd), 32'h8003);
    busRead(4'd2, rd);
    chk("R6 entry0 readback", 32'(rd), 32'h8000);

    // Fixed policy
    pulseIrq(4'b0110);
    chk("R3 fixed to core0", 32'(coreIrq), 32'h1);
    chk("R11 lowest line vector", 32'(vecOf(0)), 32'h21);
    pulseIrq(4'b0001);
    chk("R11 no delivery while pending", 32'(vecOf(0)), 32'h21);
    chk("R3 others idle", 32'(coreIrq), 32'h1);
    busWrite(4'd1, 16'h0055, 1'b1);
    chk("R12 IPI vector first", 32'(vecOf(0)), 32'h55);
    ackCores(4'b0001);
    chk("R12 ext vector after ack", 32'(vecOf(0)), 32'h21);
    chk("R10 ext still pending", 32'(coreIrq), 32'h1);
    ackCores(4'b0001);
    chk("R10 all cleared", 32'(coreIrq), 32'h0);

    // Rotating policy, cores 0 and 3 running
    busWrite(4'd0, 16'h0001, 1'b0);
    pulseIrq(4'b1000);
    chk("R4 rotate d1 core0", 32'(coreIrq), 32'h1);
    chk("R11 vector line3", 32'(vecOf(0)), 32'h23);
    ackCores(4'b0001);
    pulseIrq(4'b1000);
    chk("R4 rotate d2 skips halted", 32'(coreIrq), 32'h8);
    ackCores(4'b1000);
    busWrite(4'd1, 16'h0260, 1'b1);
    chk("R6 vid2 starts core1", 32'(coreRun), 32'hB);
    chk("R6 vid2 vector", 32'(vecOf(1)), 32'h60);
    ackCores(4'b0010);
    pulseIrq(4'b0100);
    chk("R4 rotate d3 wraps to core0", 32'(coreIrq), 32'h1);
    ackCores(4'b0001);
    pulseIrq(4'b0100);
    chk("R4 rotate d4 core1", 32'(coreIrq), 32'h2);
    ackCores(4'b0010);

    // Rotate with only core 0 running
    doReset();
    chk("R1 run after second reset", 32'(coreRun), 32'h1);
    busWrite(4'd0, 16'h0001, 1'b0);
    pulseIrq(4'b0001);
    chk("R5 fallback d1", 32'(coreIrq), 32'h1);
    ackCores(4'b0001);
    pulseIrq(4'b0001);
    chk("R5 fallback d2", 32'(coreIrq), 32'h1);
    ackCores(4'b0001);
    chk("R10 cleared", 32'(coreIrq), 32'h0);

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule